// File: doc/BRIEF.md
# Bus Glue: Region Decoder with Wait-State Acknowledge

This block is the glue logic between an asynchronous 16-bit processor bus and its local devices. It qualifies the two most significant address bits with the address strobe and turns them into a chip select for a boot ROM, a select for each byte lane of a RAM pair, and a select for a peripheral that answers the processor itself. A fourth address quadrant has no device behind it. Any access there returns a bus error.

From the two data strobes and the read/write line it produces separate write enables and output enables for the upper and lower byte. For ROM and RAM it also creates the transfer acknowledge. The combined select of those devices runs down a shift chain that is cleared while the address strobe is high. Each device takes its acknowledge from its own stage of that chain, gated by its own select. The tapped results are merged with the peripheral's active-low acknowledge into one line. A function code of all ones marks an interrupt-acknowledge cycle, and this block decodes it.

Top module: `busglue_top`

## Requirements
- R1: With `as_n` low, `fc` not 3'b111 and `addr_top` = 2'b00, `rom_cs_n` is low in the same cycle. Otherwise it is high.
- R2: With `as_n` low, `fc` not 3'b111 and `addr_top` = 2'b01, `ram_lo_cs_n` follows `lds_n` and `ram_hi_cs_n` follows `uds_n`. Both stay high in every other case.
- R3: With `as_n` low, `fc` not 3'b111 and `addr_top` = 2'b10, `per_cs_n` is low. No local acknowledge is produced for this region, so `dtack_n` follows only `periph_dtack_n`.
- R4: While `as_n` is low, the write enables behave as follows: `uwe_n` is low when `uds_n` is low and `rw` = 0 (write), and `lwe_n` likewise with `lds_n`. The output enables behave the same way for reads (`rw` = 1): `uoe_n` with `uds_n` and `loe_n` with `lds_n`.
- R5: The local acknowledge is counted in rising clock edges from the first edge at which a device select is active. ROM asserts `dtack_n` after ROM_WS edges (default 2). RAM asserts it after RAM_WS edges (default 1), and only when a lane select is active. A setting of 0 acknowledges in the same cycle. The acknowledge then stays low until `as_n` rises.
- R6: With `as_n` low, `fc` not 3'b111 and `addr_top` = 2'b11, `berr_n` is low and no local acknowledge is produced.
- R7: With `as_n` low and `fc` = 3'b111, `iack_n` is low. No ROM, RAM or peripheral select is active, `berr_n` stays high and no local acknowledge is produced.
- R8: While `as_n` is high, every select, every enable, `berr_n` and `iack_n` are high in the same cycle. `dtack_n` is also high unless `periph_dtack_n` is low. The chain is then cleared, so the next access counts its wait states from zero.
- R9: While `rst` is high, the chain stays empty. For ROM, whose wait count is above zero, `dtack_n` therefore stays high even with the select held active.
- R10: `dtack_n` is low whenever `periph_dtack_n` is low (active-low wired-OR merge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr_top | input | 2 | Two most significant address bits {A23, A22} |
| fc | input | 3 | Processor function code |
| periph_dtack_n | input | 1 | Acknowledge driven by the peripheral |
| rom_cs_n | output | 1 | ROM chip select |
| ram_lo_cs_n | output | 1 | RAM lower-lane select |
| ram_hi_cs_n | output | 1 | RAM upper-lane select |
| per_cs_n | output | 1 | Peripheral select |
| uwe_n | output | 1 | Upper byte write enable |
| lwe_n | output | 1 | Lower byte write enable |
| uoe_n | output | 1 | Upper byte output enable |
| loe_n | output | 1 | Lower byte output enable |
| dtack_n | output | 1 | Merged transfer acknowledge |
| berr_n | output | 1 | Bus error for unmapped space |
| iack_n | output | 1 | Interrupt-acknowledge cycle indicator |

## Verification
The sweep covers every quadrant, strobe pair and read/write setting, each under a normal and an interrupt-acknowledge function code. Each point is sampled at every clock of the wait window. A tap wired to the wrong stage shows up as an acknowledge one clock early or late. An interrupt-acknowledge cycle that is not masked would raise a bus error, because its address lands in the unmapped quadrant. A RAM access with both strobes high must not be acknowledged, and a lane mix-up would swap the byte enables. After each cycle the bench returns the strobe high and checks that nothing is left asserted. This catches a chain that is not cleared, which would otherwise let the next access acknowledge early.

// File: rtl/busglue_pkg.sv
package busglue_pkg;

    // Address quadrant selected by {A23, A22}
    typedef enum logic [1:0] {
        RGN_ROM  = 2'b00,
        RGN_RAM  = 2'b01,
        RGN_PER  = 2'b10,
        RGN_NONE = 2'b11
    } region_e;

    // Active-high device selects
    typedef struct packed {
        logic rom;
        logic ram_lo;
        logic ram_hi;
        logic per;
        logic unmapped;
        logic iack;
    } sel_t;

    // Active-high byte strobes
    typedef struct packed {
        logic uwe;
        logic lwe;
        logic uoe;
        logic loe;
    } strb_t;

    localparam logic [2:0] FC_INT_ACK = 3'b111;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/busglue_decode.sv
module busglue_decode
    import busglue_pkg::*;
(
    input  logic       as_n,
    input  logic       uds_n,
    input  logic       lds_n,
    input  logic [1:0] addr_top,
    input  logic [2:0] fc,
    output sel_t       sel
);
    logic    cyc;
    logic    int_ack;
    region_e rgn;

    always_comb begin
        rgn     = region_e'(addr_top);
        int_ack = (fc == FC_INT_ACK);
        cyc     = !as_n && !int_ack;

        sel          = '0;
        sel.iack     = !as_n && int_ack;
        sel.rom      = cyc && (rgn == RGN_ROM);
        sel.ram_lo   = cyc && (rgn == RGN_RAM) && !lds_n;
        sel.ram_hi   = cyc && (rgn == RGN_RAM) && !uds_n;
        sel.per      = cyc && (rgn == RGN_PER);
        sel.unmapped = cyc && (rgn == RGN_NONE);
    end
endmodule

// File: rtl/busglue_strobe.sv
module busglue_strobe
    import busglue_pkg::*;
(
    input  logic  as_n,
    input  logic  uds_n,
    input  logic  lds_n,
    input  logic  rw,
    output strb_t strb
);
    logic up, lo;

    always_comb begin
        up       = !as_n && !uds_n;
        lo       = !as_n && !lds_n;
        strb.uwe = up && !rw;
        strb.lwe = lo && !rw;
        strb.uoe = up && rw;
        strb.loe = lo && rw;
    end
endmodule

// File: rtl/busglue_wait_chain.sv
module busglue_wait_chain #(
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    input  logic             sel_in,
    output logic [DEPTH-1:0] stage
);
    // Stage k holds 1 once the select has been seen for k+1 edges.
    // A high address strobe empties the whole chain.
    always_ff @(posedge clk) begin
        if (rst || as_n) begin
            stage <= '0;
        end else begin
            stage[0] <= sel_in;
            for (int k = 1; k < int'(DEPTH); k++) begin
                stage[k] <= stage[k-1];
            end
        end
    end
endmodule

// File: rtl/busglue_top.sv
module busglue_top
    import busglue_pkg::*;
#(
    parameter int unsigned ROM_WS = 2,
    parameter int unsigned RAM_WS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       as_n,
    input  logic       uds_n,
    input  logic       lds_n,
    input  logic       rw,
    input  logic [1:0] addr_top,
    input  logic [2:0] fc,
    input  logic       periph_dtack_n,
    output logic       rom_cs_n,
    output logic       ram_lo_cs_n,
    output logic       ram_hi_cs_n,
    output logic       per_cs_n,
    output logic       uwe_n,
    output logic       lwe_n,
    output logic       uoe_n,
    output logic       loe_n,
    output logic       dtack_n,
    output logic       berr_n,
    output logic       iack_n
);
    localparam int unsigned WS_MAX    = max_u(ROM_WS, RAM_WS);
    localparam int unsigned CHAIN_LEN = (WS_MAX > 0) ? WS_MAX : 1;

    sel_t                 sel;
    strb_t                strb;
    logic                 chain_in;
    logic [CHAIN_LEN-1:0] stage;
    logic                 rom_tap, ram_tap;
    logic                 local_ack;

    busglue_decode u_dec (
        .as_n     (as_n),
        .uds_n    (uds_n),
        .lds_n    (lds_n),
        .addr_top (addr_top),
        .fc       (fc),
        .sel      (sel)
    );

    busglue_strobe u_strb (
        .as_n  (as_n),
        .uds_n (uds_n),
        .lds_n (lds_n),
        .rw    (rw),
        .strb  (strb)
    );

    assign chain_in = sel.rom || sel.ram_lo || sel.ram_hi;

    busglue_wait_chain #(.DEPTH(CHAIN_LEN)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .as_n   (as_n),
        .sel_in (chain_in),
        .stage  (stage)
    );

    // Per-device tap: zero waits uses the live select
    generate
        if (ROM_WS == 0) begin : g_rom_now
            assign rom_tap = chain_in;
        end else begin : g_rom_tap
            assign rom_tap = stage[ROM_WS-1];
        end
        if (RAM_WS == 0) begin : g_ram_now
            assign ram_tap = chain_in;
        end else begin : g_ram_tap
            assign ram_tap = stage[RAM_WS-1];
        end
    endgenerate

    assign local_ack = (sel.rom && rom_tap) || ((sel.ram_lo || sel.ram_hi) && ram_tap);

    assign rom_cs_n    = !sel.rom;
    assign ram_lo_cs_n = !sel.ram_lo;
    assign ram_hi_cs_n = !sel.ram_hi;
    assign per_cs_n    = !sel.per;
    assign berr_n      = !sel.unmapped;
    assign iack_n      = !sel.iack;
    assign uwe_n       = !strb.uwe;
    assign lwe_n       = !strb.lwe;
    assign uoe_n       = !strb.uoe;
    assign loe_n       = !strb.loe;
    assign dtack_n     = !local_ack && periph_dtack_n;
endmodule

// File: rtl/busglue_chk.sv
module busglue_chk #(
    parameter int unsigned ROM_WS = 2
) (
    input logic clk,
    input logic rst,
    input logic as_n,
    input logic periph_dtack_n,
    input logic rom_cs_n,
    input logic ram_lo_cs_n,
    input logic ram_hi_cs_n,
    input logic per_cs_n,
    input logic uwe_n,
    input logic lwe_n,
    input logic uoe_n,
    input logic loe_n,
    input logic dtack_n,
    input logic berr_n,
    input logic iack_n
);
    AST_ONE_REGION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!rom_cs_n, !(ram_lo_cs_n && ram_hi_cs_n), !per_cs_n, !berr_n, !iack_n})); // R1

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (rst)
        !((!uwe_n || !lwe_n) && (!uoe_n || !loe_n))); // R4

    AST_BERR_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (!berr_n && periph_dtack_n) |-> dtack_n); // R6

    AST_IACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !iack_n |-> (rom_cs_n && ram_lo_cs_n && ram_hi_cs_n && per_cs_n && berr_n)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (as_n && periph_dtack_n) |-> (dtack_n && rom_cs_n && berr_n && iack_n && uwe_n && uoe_n)); // R8

    AST_PERIPH_MERGE: assert property (@(posedge clk) disable iff (rst)
        !periph_dtack_n |-> !dtack_n); // R10

    generate
        if (ROM_WS > 0) begin : g_rom_wait
            AST_ROM_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
                ($fell(rom_cs_n) && periph_dtack_n) |-> dtack_n); // R5
        end
    endgenerate
endmodule

bind busglue_top busglue_chk #(.ROM_WS(ROM_WS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .as_n           (as_n),
    .periph_dtack_n (periph_dtack_n),
    .rom_cs_n       (rom_cs_n),
    .ram_lo_cs_n    (ram_lo_cs_n),
    .ram_hi_cs_n    (ram_hi_cs_n),
    .per_cs_n       (per_cs_n),
    .uwe_n          (uwe_n),
    .lwe_n          (lwe_n),
    .uoe_n          (uoe_n),
    .loe_n          (loe_n),
    .dtack_n        (dtack_n),
    .berr_n         (berr_n),
    .iack_n         (iack_n)
);

// File: tb/tb_busglue_top.sv
module tb_busglue_top;
    localparam int ROM_WS = 2;
    localparam int RAM_WS = 1;
    localparam int PER_WS = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       as_n, uds_n, lds_n, rw, periph_dtack_n;
    logic [1:0] addr_top;
    logic [2:0] fc;
    logic       rom_cs_n, ram_lo_cs_n, ram_hi_cs_n, per_cs_n;
    logic       uwe_n, lwe_n, uoe_n, loe_n, dtack_n, berr_n, iack_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    busglue_top #(.ROM_WS(ROM_WS), .RAM_WS(RAM_WS)) dut (
        .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .rw(rw), .addr_top(addr_top), .fc(fc), .periph_dtack_n(periph_dtack_n),
        .rom_cs_n(rom_cs_n), .ram_lo_cs_n(ram_lo_cs_n), .ram_hi_cs_n(ram_hi_cs_n),
        .per_cs_n(per_cs_n), .uwe_n(uwe_n), .lwe_n(lwe_n), .uoe_n(uoe_n),
        .loe_n(loe_n), .dtack_n(dtack_n), .berr_n(berr_n), .iack_n(iack_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (addr=%b fc=%b rw=%b uds=%b lds=%b)",
                     tag, act, exp, addr_top, fc, rw, uds_n, lds_n);
        end
    endtask

    task automatic run_cycle(input logic [1:0] a, input logic [2:0] f, input logic r,
                             input logic u, input logic l);
        bit ia, erom, eraml, eramh, eper, eber, eack;
        ia    = (f == 3'b111);
        erom  = !ia && (a == 2'd0);
        eraml = !ia && (a == 2'd1) && !l;
        eramh = !ia && (a == 2'd1) && !u;
        eper  = !ia && (a == 2'd2);
        eber  = !ia && (a == 2'd3);

        @(negedge clk);
        addr_top = a; fc = f; rw = r; uds_n = u; lds_n = l;
        periph_dtack_n = 1'b1; as_n = 1'b0;
        #1;
        chk("R1 rom select", {7'd0, rom_cs_n}, {7'd0, !erom});
        chk("R2 ram lanes", {6'd0, ram_hi_cs_n, ram_lo_cs_n}, {6'd0, !eramh, !eraml});
        chk("R3 periph select", {7'd0, per_cs_n}, {7'd0, !eper});
        chk("R6 bus error", {7'd0, berr_n}, {7'd0, !eber});
        chk("R7 iack", {7'd0, iack_n}, {7'd0, !ia});
        chk("R4 byte strobes", {4'd0, uwe_n, lwe_n, uoe_n, loe_n},
            {4'd0, !(!u && !r), !(!l && !r), !(!u && r), !(!l && r)});

        for (int j = 0; j <= 4; j++) begin
            if (j > 0) begin
                @(negedge clk);
                periph_dtack_n = !(eper && j >= PER_WS);
                #1;
            end
            eack = (erom && j >= ROM_WS) || ((eraml || eramh) && j >= RAM_WS)
                   || (eper && j >= PER_WS);
            if (eper)
                chk("R3/R10 periph ack merge", {7'd0, dtack_n}, {7'd0, !eack});
            else
                chk("R5 wait-state ack timing", {7'd0, dtack_n}, {7'd0, !eack});
        end

        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; periph_dtack_n = 1'b1;
        #1;
        chk("R8 idle outputs",
            {rom_cs_n, ram_lo_cs_n, ram_hi_cs_n, per_cs_n, berr_n, iack_n, dtack_n,
             uwe_n & lwe_n & uoe_n & loe_n},
            8'hFF);
        @(posedge clk);
    endtask

    initial begin
        rst = 1'b1; as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw = 1'b1;
        addr_top = 2'd0; fc = 3'b101; periph_dtack_n = 1'b1;

        // R9: reset holds the chain empty even with ROM selected
        @(negedge clk);
        as_n = 1'b0; lds_n = 1'b0; uds_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9 reset blocks ack", {7'd0, dtack_n}, 8'd1);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        // R10: peripheral acknowledge passes with the strobe idle
        periph_dtack_n = 1'b0;
        #1;
        chk("R10 merge while idle", {7'd0, dtack_n}, 8'd0);
        @(negedge clk);
        periph_dtack_n = 1'b1;
        #1;
        chk("R8 idle after merge", {7'd0, dtack_n}, 8'd1);

        for (int a = 0; a < 4; a++)
            for (int fs = 0; fs < 2; fs++)
                for (int r = 0; r < 2; r++)
                    for (int d = 0; d < 4; d++)
                        run_cycle(2'(a), (fs == 0) ? 3'b101 : 3'b111, 1'(r),
                                  d[1], d[0]);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule